// File: doc/BRIEF.md
# Store-Coherent Instruction Cache

This block is a small set-associative cache placed between an instruction-fetch port and a memory that holds both code and data. Only fetch reads allocate lines. Data loads go to memory over a separate path, so they never reach the block. Every data store is also presented to the cache on a snoop port. Any cached copy of the stored bytes is patched in place in the cycle the store appears. A program can therefore write new code and jump to it without a flush or barrier step.

The cache holds 256 bytes: 4 sets of 4 ways, with 16-byte lines. A 32-bit address splits into three fields:
- bits [3:0] give the byte within the line, and bits [3:2] select the word;
- bits [5:4] give the set;
- bits [31:6] form the tag.

On a lookup, the four tags of the selected set are compared at the same time. A hit answers on the next cycle. A miss stalls the fetch port and issues one line-aligned burst of four 32-bit beats. That burst fills a line buffer, which is also exposed to stores that arrive during the refill. The victim is an invalid way if the set has one; otherwise a 3-bit pseudo-LRU tree per set chooses it. A single-cycle invalidate input drops every line.

Top module: `wc_icache`

## Requirements
- R1: After reset, `fetch_ready` is 1, `rsp_valid` is 0, `mem_req` is 0, and no line is valid.
- R2: A fetch that misses drops `fetch_ready` and raises `mem_req`, with `mem_addr` set to the line address (low four bits zero). `rsp_valid` rises one cycle after the fourth beat arrives, and `rsp_data` carries the requested word.
- R3: A fetch that hits gives `rsp_valid` with the cached word in the cycle after the request is accepted, and it issues no memory request.
- R4: All four ways of a set can hold lines with different tags at once, and each of those lines then hits.
- R5: Replacement works as follows. An invalid way is used first. Otherwise, each set keeps a 3-bit tree that is updated on every hit and every fill, and the tree selects the victim. Example: fill tags A, B, C, D into one set in that order, then hit A. The next miss in that set evicts C, and A, B and D still hit.
- R6: A snoop store that hits a valid line writes the bytes whose `snoop_be` bit is set (bit i covers data bits 8i+7..8i). Later fetches of that word return the merged value.
- R7: A snoop store in the same cycle as a hitting fetch of the same word is already visible in that fetch's response.
- R8: A snoop store to an address that is not cached allocates nothing, so a later fetch of that address still misses.
- R9: A snoop store to the line being refilled is kept. Memory beats that arrive later for those bytes do not overwrite them.
- R10: A one-cycle pulse on `inv_all` clears every valid bit, so the next fetch of any address misses.
- R11: Each miss produces exactly one burst of four beats from the same line address, with `mem_req` held high until the last beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inv_all | input | 1 | Invalidate every line |
| fetch_valid | input | 1 | Fetch request present |
| fetch_addr | input | 32 | Fetch byte address (word-aligned) |
| fetch_ready | output | 1 | Cache can accept a fetch |
| rsp_valid | output | 1 | Fetch response valid |
| rsp_data | output | 32 | Fetched instruction word |
| snoop_valid | input | 1 | Data store seen on the store path |
| snoop_addr | input | 32 | Store byte address |
| snoop_be | input | 4 | Store byte enables |
| snoop_data | input | 32 | Store data |
| mem_req | output | 1 | Burst line read pending |
| mem_addr | output | 32 | Line-aligned burst address |
| mem_rvalid | input | 1 | Burst beat valid |
| mem_rdata | input | 32 | Burst beat data |

## Verification
The ports expose most internal faults quickly:
- A corrupted tag or valid bit shows up on the next fetch to that line: a burst appears where a one-cycle hit was expected, or stale data comes back.
- A wrong pseudo-LRU tree evicts the wrong line. This is only visible once a set fills and the extra miss appears.
- A lost snoop patch or a lost racing store returns old bytes on the first later fetch of that word.
- A broken beat count shows as a response that arrives early or late relative to the fourth beat.

// File: rtl/wc_icache_pkg.sv
package wc_icache_pkg;
    localparam int ADDR_W         = 32;
    localparam int WORD_W         = 32;
    localparam int BYTES_PER_WORD = WORD_W / 8;
    localparam int WORDS_PER_LINE = 4;
    localparam int NUM_SETS       = 4;
    localparam int NUM_WAYS       = 4;
    localparam int BSEL_W         = $clog2(BYTES_PER_WORD);
    localparam int WSEL_W         = $clog2(WORDS_PER_LINE);
    localparam int SET_W          = $clog2(NUM_SETS);
    localparam int WAY_W          = $clog2(NUM_WAYS);
    localparam int TAG_W          = ADDR_W - SET_W - WSEL_W - BSEL_W;
    localparam int PLRU_W         = NUM_WAYS - 1;
    localparam int LINE_BYTES     = WORDS_PER_LINE * BYTES_PER_WORD;

    typedef logic [WORD_W-1:0]         word_t;
    typedef logic [BYTES_PER_WORD-1:0] be_t;
    typedef logic [WORDS_PER_LINE-1:0][WORD_W-1:0] line_t;

    typedef struct packed {
        logic [TAG_W-1:0]  tag;
        logic [SET_W-1:0]  set;
        logic [WSEL_W-1:0] word;
        logic [BSEL_W-1:0] boff;
    } iaddr_t;

    typedef enum logic {FS_IDLE, FS_FILL} fsm_e;

    function automatic word_t merge_word(word_t old_w, word_t new_w, be_t be);
        word_t r = old_w;
        for (int b = 0; b < BYTES_PER_WORD; b++)
            if (be[b]) r[b*8 +: 8] = new_w[b*8 +: 8];
        return r;
    endfunction

    // tree bit 0: 0 = victim in ways 0/1, 1 = victim in ways 2/3
    // tree bit 1: victim inside ways 0/1; tree bit 2: victim inside ways 2/3
    function automatic logic [WAY_W-1:0] plru_pick(logic [PLRU_W-1:0] t);
        return t[0] ? {1'b1, t[2]} : {1'b0, t[1]};
    endfunction

    function automatic logic [PLRU_W-1:0] plru_touch(logic [PLRU_W-1:0] t, logic [WAY_W-1:0] w);
        logic [PLRU_W-1:0] r = t;
        if (!w[1]) begin
            r[0] = 1'b1;
            r[1] = ~w[0];
        end else begin
            r[0] = 1'b0;
            r[2] = ~w[0];
        end
        return r;
    endfunction
endpackage

// File: rtl/wc_icache_plru.sv
module wc_icache_plru
    import wc_icache_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             touch_en,
    input  logic [SET_W-1:0] touch_set,
    input  logic [WAY_W-1:0] touch_way,
    input  logic [SET_W-1:0] query_set,
    input  logic [NUM_WAYS-1:0] query_valid,
    output logic [WAY_W-1:0] victim_way
);
    logic [PLRU_W-1:0] tree_q [NUM_SETS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < NUM_SETS; s++) tree_q[s] <= '0;
        end else if (touch_en) begin
            tree_q[touch_set] <= plru_touch(tree_q[touch_set], touch_way);
        end
    end

    always_comb begin
        logic found;
        found      = 1'b0;
        victim_way = plru_pick(tree_q[query_set]);
        for (int w = 0; w < NUM_WAYS; w++) begin
            if (!found && !query_valid[w]) begin
                victim_way = WAY_W'(w);
                found      = 1'b1;
            end
        end
    end

    // an invalid way must be chosen before any valid one
    assert_victim_invalid_first_R5: assert property (@(posedge clk) disable iff (rst)
        (query_valid != {NUM_WAYS{1'b1}}) |-> !query_valid[victim_way]);
endmodule

// File: rtl/wc_icache_tags.sv
module wc_icache_tags
    import wc_icache_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                inv_all,
    input  logic                fill_en,
    input  logic [SET_W-1:0]    fill_set,
    input  logic [WAY_W-1:0]    fill_way,
    input  logic [TAG_W-1:0]    fill_tag,
    input  logic [SET_W-1:0]    look_set,
    input  logic [TAG_W-1:0]    look_tag,
    output logic [NUM_WAYS-1:0] look_hit,
    output logic [NUM_WAYS-1:0] look_valid,
    input  logic [SET_W-1:0]    snp_set,
    input  logic [TAG_W-1:0]    snp_tag,
    output logic [NUM_WAYS-1:0] snp_hit
);
    logic [NUM_WAYS-1:0] valid_q [NUM_SETS];
    logic [TAG_W-1:0]    tag_q   [NUM_SETS][NUM_WAYS];
    logic                any_valid;

    always_ff @(posedge clk) begin
        if (rst || inv_all) begin
            for (int s = 0; s < NUM_SETS; s++) valid_q[s] <= '0;
        end else if (fill_en) begin
            valid_q[fill_set][fill_way] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (fill_en) tag_q[fill_set][fill_way] <= fill_tag;
    end

    // all ways of a set compared side by side
    for (genvar w = 0; w < NUM_WAYS; w++) begin : g_cmp
        assign look_hit[w] = valid_q[look_set][w] && (tag_q[look_set][w] == look_tag);
        assign snp_hit[w]  = valid_q[snp_set][w]  && (tag_q[snp_set][w]  == snp_tag);
    end
    assign look_valid = valid_q[look_set];

    always_comb begin
        any_valid = 1'b0;
        for (int s = 0; s < NUM_SETS; s++) any_valid = any_valid | (|valid_q[s]);
    end

    assert_single_way_hit_R4: assert property (@(posedge clk) disable iff (rst)
        $onehot0(look_hit) && $onehot0(snp_hit));

    assert_invalidate_clears_R10: assert property (@(posedge clk) disable iff (rst)
        inv_all |=> !any_valid);
endmodule

// File: rtl/wc_icache_data.sv
module wc_icache_data
    import wc_icache_pkg::*;
(
    input  logic              clk,
    input  logic              fill_en,
    input  logic [SET_W-1:0]  fill_set,
    input  logic [WAY_W-1:0]  fill_way,
    input  line_t             fill_line,
    input  logic              patch_en,
    input  logic [SET_W-1:0]  patch_set,
    input  logic [WAY_W-1:0]  patch_way,
    input  logic [WSEL_W-1:0] patch_word,
    input  be_t               patch_be,
    input  word_t             patch_data,
    input  logic [SET_W-1:0]  rd_set,
    input  logic [WAY_W-1:0]  rd_way,
    input  logic [WSEL_W-1:0] rd_word,
    output word_t             rd_data
);
    line_t lines_q [NUM_SETS][NUM_WAYS];

    always_ff @(posedge clk) begin
        if (patch_en)
            lines_q[patch_set][patch_way][patch_word] <=
                merge_word(lines_q[patch_set][patch_way][patch_word], patch_data, patch_be);
        // a fill replaces the whole line; its buffer already carries racing stores
        if (fill_en)
            lines_q[fill_set][fill_way] <= fill_line;
    end

    assign rd_data = lines_q[rd_set][rd_way][rd_word];
endmodule

// File: rtl/wc_icache_fill.sv
module wc_icache_fill
    import wc_icache_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              beat_valid,
    input  word_t             beat_data,
    input  logic              snp_match,
    input  logic [WSEL_W-1:0] snp_word,
    input  be_t               snp_be,
    input  word_t             snp_data,
    output line_t             line_next,
    output logic              last_beat
);
    line_t                  buf_q;
    logic [LINE_BYTES-1:0]  lock_q, lock_next;
    logic [WSEL_W-1:0]      beat_q;

    always_comb begin
        line_next = buf_q;
        lock_next = start ? '0 : lock_q;
        if (beat_valid) begin
            for (int b = 0; b < BYTES_PER_WORD; b++)
                if (!lock_next[int'(beat_q)*BYTES_PER_WORD + b])
                    line_next[beat_q][b*8 +: 8] = beat_data[b*8 +: 8];
        end
        // a store landing on the pending line wins over memory, now and later
        if (snp_match) begin
            for (int b = 0; b < BYTES_PER_WORD; b++) begin
                if (snp_be[b]) begin
                    line_next[snp_word][b*8 +: 8] = snp_data[b*8 +: 8];
                    lock_next[int'(snp_word)*BYTES_PER_WORD + b] = 1'b1;
                end
            end
        end
        last_beat = beat_valid && (beat_q == WSEL_W'(WORDS_PER_LINE - 1));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            beat_q <= '0;
            lock_q <= '0;
        end else begin
            lock_q <= lock_next;
            if (start)           beat_q <= '0;
            else if (beat_valid) beat_q <= beat_q + 1'b1;
        end
    end

    always_ff @(posedge clk) buf_q <= line_next;
endmodule

// File: rtl/wc_icache.sv
module wc_icache
    import wc_icache_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              inv_all,
    input  logic              fetch_valid,
    input  logic [ADDR_W-1:0] fetch_addr,
    output logic              fetch_ready,
    output logic              rsp_valid,
    output logic [WORD_W-1:0] rsp_data,
    input  logic              snoop_valid,
    input  logic [ADDR_W-1:0] snoop_addr,
    input  logic [BYTES_PER_WORD-1:0] snoop_be,
    input  logic [WORD_W-1:0] snoop_data,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_rvalid,
    input  logic [WORD_W-1:0] mem_rdata
);
    fsm_e   state_q;
    iaddr_t req_a, snp_a, miss_q;
    logic [WAY_W-1:0] way_q, hit_way, snp_way, victim_way;
    logic [NUM_WAYS-1:0] look_hit, look_valid, snp_hit;
    logic   accept, hit, miss_start, fill_done, last_beat, beat_valid;
    logic   patch_en, snp_fill_match, same_word;
    logic [TAG_W+SET_W-1:0] pend_line;
    line_t  line_next;
    word_t  rd_data, hit_word;
    logic   rsp_valid_q;
    word_t  rsp_data_q;

    assign req_a = iaddr_t'(fetch_addr);
    assign snp_a = iaddr_t'(snoop_addr);

    assign fetch_ready = (state_q == FS_IDLE);
    assign accept      = fetch_valid && fetch_ready;
    assign hit         = |look_hit;
    assign miss_start  = accept && !hit;
    assign beat_valid  = mem_rvalid && (state_q == FS_FILL);
    assign fill_done   = (state_q == FS_FILL) && last_beat;

    always_comb begin
        hit_way = '0;
        snp_way = '0;
        for (int w = 0; w < NUM_WAYS; w++) begin
            if (look_hit[w]) hit_way = WAY_W'(w);
            if (snp_hit[w])  snp_way = WAY_W'(w);
        end
    end

    assign patch_en  = snoop_valid && (|snp_hit);
    assign pend_line = (state_q == FS_IDLE) ? {req_a.tag, req_a.set} : {miss_q.tag, miss_q.set};
    assign snp_fill_match = snoop_valid && (miss_start || state_q == FS_FILL)
                            && ({snp_a.tag, snp_a.set} == pend_line);
    assign same_word = snoop_valid &&
                       (snoop_addr[ADDR_W-1:BSEL_W] == fetch_addr[ADDR_W-1:BSEL_W]);
    assign hit_word  = same_word ? merge_word(rd_data, snoop_data, snoop_be) : rd_data;

    wc_icache_tags u_tags (
        .clk(clk), .rst(rst), .inv_all(inv_all),
        .fill_en(fill_done), .fill_set(miss_q.set), .fill_way(way_q), .fill_tag(miss_q.tag),
        .look_set(req_a.set), .look_tag(req_a.tag), .look_hit(look_hit), .look_valid(look_valid),
        .snp_set(snp_a.set), .snp_tag(snp_a.tag), .snp_hit(snp_hit)
    );

    wc_icache_data u_data (
        .clk(clk),
        .fill_en(fill_done), .fill_set(miss_q.set), .fill_way(way_q), .fill_line(line_next),
        .patch_en(patch_en), .patch_set(snp_a.set), .patch_way(snp_way),
        .patch_word(snp_a.word), .patch_be(snoop_be), .patch_data(snoop_data),
        .rd_set(req_a.set), .rd_way(hit_way), .rd_word(req_a.word), .rd_data(rd_data)
    );

    wc_icache_plru u_plru (
        .clk(clk), .rst(rst),
        .touch_en((accept && hit) || fill_done),
        .touch_set(fill_done ? miss_q.set : req_a.set),
        .touch_way(fill_done ? way_q : hit_way),
        .query_set(req_a.set), .query_valid(look_valid), .victim_way(victim_way)
    );

    wc_icache_fill u_fill (
        .clk(clk), .rst(rst), .start(miss_start),
        .beat_valid(beat_valid), .beat_data(mem_rdata),
        .snp_match(snp_fill_match), .snp_word(snp_a.word), .snp_be(snoop_be), .snp_data(snoop_data),
        .line_next(line_next), .last_beat(last_beat)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= FS_IDLE;
            rsp_valid_q <= 1'b0;
        end else begin
            rsp_valid_q <= (accept && hit) || fill_done;
            if (miss_start)     state_q <= FS_FILL;
            else if (fill_done) state_q <= FS_IDLE;
        end
    end

    always_ff @(posedge clk) begin
        if (miss_start) begin
            miss_q <= req_a;
            way_q  <= victim_way;
        end
        if (fill_done)          rsp_data_q <= line_next[miss_q.word];
        else if (accept && hit) rsp_data_q <= hit_word;
    end

    assign rsp_valid = rsp_valid_q;
    assign rsp_data  = rsp_data_q;
    assign mem_req   = (state_q == FS_FILL);
    assign mem_addr  = {miss_q.tag, miss_q.set, {(WSEL_W + BSEL_W){1'b0}}};

    // independent beat counter for the burst-length check
    logic [WSEL_W:0] obs_beats_q;
    always_ff @(posedge clk) begin
        if (rst || miss_start)          obs_beats_q <= '0;
        else if (mem_rvalid && mem_req) obs_beats_q <= obs_beats_q + 1'b1;
    end

    assert_hit_next_cycle_R3: assert property (@(posedge clk) disable iff (rst)
        (accept && hit) |=> (rsp_valid && !mem_req));

    assert_miss_stalls_R2: assert property (@(posedge clk) disable iff (rst)
        miss_start |=> (mem_req && !rsp_valid && !fetch_ready));

    assert_four_beats_R11: assert property (@(posedge clk) disable iff (rst)
        fill_done |-> (obs_beats_q == (WSEL_W+1)'(WORDS_PER_LINE - 1)));

    assert_burst_addr_stable_R11: assert property (@(posedge clk) disable iff (rst)
        (mem_req && $past(mem_req)) |-> $stable(mem_addr));
endmodule

// File: tb/wc_icache_test.sv
`timescale 1ns/1ps
module wc_icache_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        inv_all = 1'b0;
    logic        fetch_valid = 1'b0;
    logic [31:0] fetch_addr = '0;
    logic        fetch_ready, rsp_valid, mem_req;
    logic [31:0] rsp_data, mem_addr;
    logic        snoop_valid = 1'b0;
    logic [31:0] snoop_addr = '0;
    logic [3:0]  snoop_be = '0;
    logic [31:0] snoop_data = '0;
    logic        mem_rvalid = 1'b0;
    logic [31:0] mem_rdata = '0;

    int checks = 0;
    int errors = 0;
    int burst_count = 0;
    bit done = 0;

    always #2 clk = ~clk;

    wc_icache uut (
        .clk(clk), .rst(rst), .inv_all(inv_all),
        .fetch_valid(fetch_valid), .fetch_addr(fetch_addr), .fetch_ready(fetch_ready),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .snoop_valid(snoop_valid), .snoop_addr(snoop_addr), .snoop_be(snoop_be), .snoop_data(snoop_data),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
    );

    function automatic logic [31:0] mem_val(logic [31:0] a);
        return ({a[31:2], 2'b00} * 32'h9E3779B1) ^ 32'h5A5A1234;
    endfunction

    function automatic logic [31:0] bytes_over(logic [31:0] base, logic [31:0] nw, logic [3:0] be);
        logic [31:0] r = base;
        for (int i = 0; i < 4; i++) if (be[i]) r[i*8 +: 8] = nw[i*8 +: 8];
        return r;
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    // memory model: stores are not applied here, so returned data is always the original
    int beat_idx = 0;
    int lat = 0;
    bit busy = 0;
    logic [31:0] base = '0;
    always @(negedge clk) begin
        mem_rvalid = 1'b0;
        if (!rst && !busy && mem_req) begin
            busy = 1; lat = 2; beat_idx = 0; base = mem_addr; burst_count++;
            check("R2 line-aligned mem_addr", {28'd0, mem_addr[3:0]}, 32'd0);
        end else if (busy) begin
            if (lat > 0) lat--;
            else begin
                check("R11 mem_req held during burst", {31'd0, mem_req}, 32'd1);
                check("R11 burst address stable", mem_addr, base);
                mem_rvalid = 1'b1;
                mem_rdata  = mem_val(base + 32'(beat_idx * 4));
                beat_idx++;
                if (beat_idx == 4) busy = 0;
            end
        end
    end

    task automatic do_fetch(input logic [31:0] a, output logic [31:0] d, output int cyc, output int bursts);
        int b0;
        @(negedge clk);
        fetch_valid = 1'b1; fetch_addr = a; b0 = burst_count;
        @(negedge clk);
        fetch_valid = 1'b0; cyc = 1;
        while (!rsp_valid && cyc < 100) begin @(negedge clk); cyc++; end
        d = rsp_data; bursts = burst_count - b0;
    endtask

    task automatic do_store(input logic [31:0] a, input logic [3:0] be, input logic [31:0] v);
        @(negedge clk);
        snoop_valid = 1'b1; snoop_addr = a; snoop_be = be; snoop_data = v;
        @(negedge clk);
        snoop_valid = 1'b0;
    endtask

    // {expect_hit, address}; set 0 tags A..E at 0x1000..0x5000
    localparam logic [32:0] VEC [13] = '{
        {1'b0, 32'h0000_1000}, {1'b1, 32'h0000_1004}, {1'b1, 32'h0000_100C},
        {1'b0, 32'h0000_1010}, {1'b0, 32'h0000_2008}, {1'b0, 32'h0000_3000},
        {1'b0, 32'h0000_4004}, {1'b1, 32'h0000_1008}, {1'b0, 32'h0000_5000},
        {1'b1, 32'h0000_2000}, {1'b1, 32'h0000_4000}, {1'b1, 32'h0000_1000},
        {1'b0, 32'h0000_3000}
    };

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL R2 watchdog actual hung expected completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        int cyc, bursts;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check("R1 fetch_ready", {31'd0, fetch_ready}, 32'd1);
        check("R1 rsp_valid",   {31'd0, rsp_valid},   32'd0);
        check("R1 mem_req",     {31'd0, mem_req},     32'd0);

        // table walk: R2 misses, R3 hits, R4 four ways in set 0, R5 replacement at the last entry
        for (int i = 0; i < 13; i++) begin
            do_fetch(VEC[i][31:0], d, cyc, bursts);
            check(VEC[i][32] ? "R3 hit data" : "R2 miss data", d, mem_val(VEC[i][31:0]));
            check(i == 12 ? "R5 evicted way misses" : (i >= 9 ? "R4 way retained" : "R2/R3 burst count"),
                  32'(bursts), VEC[i][32] ? 32'd0 : 32'd1);
            if (VEC[i][32]) check("R3 hit latency", 32'(cyc), 32'd1);
        end

        // R6 store patch on a cached line
        do_store(32'h0000_1004, 4'b0101, 32'hDEAD_BEEF);
        do_fetch(32'h0000_1004, d, cyc, bursts);
        check("R6 patched word", d, bytes_over(mem_val(32'h1004), 32'hDEAD_BEEF, 4'b0101));
        check("R6 still a hit", 32'(bursts), 32'd0);

        // R7 store in the same cycle as the hitting fetch
        @(negedge clk);
        fetch_valid = 1'b1; fetch_addr = 32'h0000_2000;
        snoop_valid = 1'b1; snoop_addr = 32'h0000_2000; snoop_be = 4'b0011; snoop_data = 32'h0000_7777;
        @(negedge clk);
        fetch_valid = 1'b0; snoop_valid = 1'b0;
        check("R7 rsp_valid", {31'd0, rsp_valid}, 32'd1);
        check("R7 same-cycle store visible", rsp_data, bytes_over(mem_val(32'h2000), 32'h0000_7777, 4'b0011));

        // R8 store to an uncached address must not allocate
        do_store(32'h0000_7000, 4'hF, 32'h1111_2222);
        do_fetch(32'h0000_7000, d, cyc, bursts);
        check("R8 no allocation on store", 32'(bursts), 32'd1);
        check("R8 data from memory", d, mem_val(32'h7000));

        // R9 stores racing the refill of their own line
        @(negedge clk);
        fetch_valid = 1'b1; fetch_addr = 32'h0000_8004;
        @(negedge clk);
        fetch_valid = 1'b0;
        snoop_valid = 1'b1; snoop_addr = 32'h0000_8004; snoop_be = 4'hF; snoop_data = 32'hC0DE_0001;
        @(negedge clk);
        snoop_addr = 32'h0000_800C; snoop_be = 4'b1000; snoop_data = 32'hAB00_0000;
        @(negedge clk);
        snoop_valid = 1'b0;
        cyc = 0;
        while (!rsp_valid && cyc < 100) begin @(negedge clk); cyc++; end
        check("R9 critical word keeps store", rsp_data, 32'hC0DE_0001);
        do_fetch(32'h0000_800C, d, cyc, bursts);
        check("R9 other word keeps store", d, bytes_over(mem_val(32'h800C), 32'hAB00_0000, 4'b1000));
        check("R9 line valid after fill", 32'(bursts), 32'd0);

        // R10 invalidate all
        @(negedge clk);
        inv_all = 1'b1;
        @(negedge clk);
        inv_all = 1'b0;
        do_fetch(32'h0000_800C, d, cyc, bursts);
        check("R10 miss after invalidate", 32'(bursts), 32'd1);
        check("R10 refetched data", d, mem_val(32'h800C));
        do_fetch(32'h0000_800C, d, cyc, bursts);
        check("R11 single burst then hit", 32'(bursts), 32'd0);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule